// File: doc/BRIEF.md
# Instruction Skip Control Unit

This unit sits between instruction fetch and execute in a small 4-bit processor and decides, for each instruction word presented, whether that word is executed or suppressed. A word that is suppressed becomes a no-operation. Two mechanisms can cause suppression. The first is a one-bit skip flag, which compare and arithmetic instructions load from a condition that the datapath supplies. The second is a run detector for immediate loads. Within a run of consecutive immediate loads of the same kind, only the first load takes effect.

Fetch presents one word per valid beat. It also marks the first word of any two-word instruction. When an instruction is suppressed, all of its words are suppressed. A two-word instruction that alters the skip flag takes its condition on its second word. The kill output is combinational, so execute can gate the word in the same cycle.

Top module: `skip_ctrl`

## Requirements
- R1: After reset the skip flag is clear and no previous opcode is recorded, so the first instruction word is never killed. `kill` is low whenever `op_valid` is low.
- R2: An executed flag-loading instruction with `sf_cond`=1 causes the next instruction to be killed. The flag-loading opcodes are 0110xxxx, 00100010, 000001xx, 00011100, 00001111, 00001110, 00101000 and 00100000.
- R3: An executed flag-loading instruction with `sf_cond`=0 leaves the next instruction executing.
- R4: The instruction killed by the flag clears the flag, so the instruction after it executes unless another rule applies.
- R5: Opcodes outside the flag-loading set ignore `sf_cond`, and the following instruction executes.
- R6: An immediate accumulator load (0111xxxx) that directly follows another one is killed.
- R7: An immediate L-register load (0100xxxx) that directly follows another one is killed.
- R8: The H-bit writes 00100101 and 00100100 count as one kind, so either is killed when it directly follows either of them.
- R9: A killed member of a run still counts as the previous instruction, so every member of a run after the first is killed. A different opcode between two loads breaks the run.
- R10: When the first word of a two-word instruction (`op_two_word`=1) is killed, its second word is killed too. Second words never update the run history. A two-word flag-loading instruction loads the flag from `sf_cond` on its second word.
- R11: Cycles with `op_valid` low change neither the flag nor the run history.
- R12: A killed instruction never sets the flag, whatever `sf_cond` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An instruction word is presented this cycle |
| op_code | input | 8 | The instruction word presented |
| op_two_word | input | 1 | The presented word is the first word of a two-word instruction |
| sf_cond | input | 1 | Datapath condition for the instruction completing this beat |
| kill | output | 1 | Suppress the presented word |

## Verification
Properties are checked on every cycle. These cover: the flag clears after it kills a word; the flag and history hold while the input is idle; a history hit forces a kill; a killed first word arms the kill of its second word; and the flag rises only after an executed word. Other behaviour can be shown only by instruction sequences. This covers whole runs of loads, the merging of the two H-bit writes, breaking a run with an unrelated opcode, the flag condition that arrives on the second word, and the interplay between the flag and the run rule. A bench reference model replays these sequences in directed and random mixes.

// File: rtl/skip_pkg.sv
// Shared types and opcode classification for the skip control unit.
// Assumes 8-bit opcodes, with the encodings listed in the requirements.
package skip_pkg;

    localparam int OPC_W = 8;

    typedef enum logic [1:0] {
        RUN_NONE = 2'd0,
        RUN_ACC  = 2'd1,
        RUN_LREG = 2'd2,
        RUN_HBIT = 2'd3
    } run_kind_e;

    // Kind of immediate load that takes part in the run rule.
    function automatic run_kind_e classify_run(input logic [OPC_W-1:0] op);
        if (op[7:4] == 4'b0111)      return RUN_ACC;
        else if (op[7:4] == 4'b0100) return RUN_LREG;
        else if (op[7:1] == 7'b0010010) return RUN_HBIT;
        else                         return RUN_NONE;
    endfunction

    // True for opcodes that load the skip flag from the datapath condition.
    function automatic logic loads_flag(input logic [OPC_W-1:0] op);
        return (op[7:4] == 4'b0110) ||
               (op[7:2] == 6'b000001) ||
               (op == 8'b00100010) ||
               (op == 8'b00011100) ||
               (op == 8'b00001111) ||
               (op == 8'b00001110) ||
               (op == 8'b00101000) ||
               (op == 8'b00100000);
    endfunction

endpackage

// File: rtl/skip_decode.sv
// Opcode classifier: this module reports the run kind of a word and
// whether the word loads the skip flag. It is purely combinational.
module skip_decode
    import skip_pkg::*;
#(
    parameter int W = OPC_W
) (
    input  logic [W-1:0] opcode,
    output run_kind_e    kind,
    output logic         flag_load
);
    // Classify the presented word.
    always_comb begin
        kind      = classify_run(opcode);
        flag_load = loads_flag(opcode);
    end
endmodule

// File: rtl/skip_history.sv
// Run history: this module remembers the run kind of the last first-word
// beat, whether that word was killed or not. It flags a hit when the
// current first word has the same non-empty kind. It assumes that
// second words are excluded through first_beat.
module skip_history
    import skip_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      first_beat,
    input  logic      beat,
    input  run_kind_e kind,
    output logic      repeat_hit
);
    run_kind_e hist_q;

    // Record the kind of each first word. Reset forgets the history.
    always_ff @(posedge clk) begin
        if (!rst_n)          hist_q <= RUN_NONE;
        else if (first_beat) hist_q <= kind;
    end

    // Compare the current word against the recorded kind.
    always_comb repeat_hit = (kind != RUN_NONE) && (kind == hist_q);

    AST_HIST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !beat |=> $stable(hist_q)); // R11
endmodule

// File: rtl/skip_flag.sv
// Skip flag and two-word tracking. This module holds the flag, knows
// whether the next beat is a second word, and whether that second word
// must be dropped. It assumes that op_two_word is meaningful on first
// words only.
module skip_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic beat,
    input  logic two_word,
    input  logic flag_load,
    input  logic cond,
    input  logic kill,
    output logic sf_q,
    output logic in_second,
    output logic drop_q
);
    logic pend_q;

    // Advance the flag and the word phase on every valid beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sf_q      <= 1'b0;
            in_second <= 1'b0;
            drop_q    <= 1'b0;
            pend_q    <= 1'b0;
        end else if (beat) begin
            if (in_second) begin
                sf_q      <= !drop_q && pend_q && cond;
                in_second <= 1'b0;
                drop_q    <= 1'b0;
                pend_q    <= 1'b0;
            end else if (two_word) begin
                sf_q      <= 1'b0;
                in_second <= 1'b1;
                drop_q    <= kill;
                pend_q    <= !kill && flag_load;
            end else begin
                sf_q      <= !kill && flag_load && cond;
            end
        end
    end

    AST_SF_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !in_second && sf_q) |=> !sf_q); // R4
    AST_SF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !beat |=> $stable(sf_q)); // R11
    AST_OPERAND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !in_second && two_word && kill) |=> (in_second && drop_q)); // R10
    AST_SF_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sf_q) |-> ($past(beat) && !$past(kill))); // R12
endmodule

// File: rtl/skip_ctrl.sv
// Top of the skip control unit. It combines the skip flag, the run
// history and the two-word tracking into one kill for the presented word.
// It assumes one instruction word per valid beat, in program order.
module skip_ctrl
    import skip_pkg::*;
#(
    parameter int OP_W = OPC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_code,
    input  logic            op_two_word,
    input  logic            sf_cond,
    output logic            kill
);
    run_kind_e kind;
    logic      flag_load;
    logic      repeat_hit;
    logic      sf_q;
    logic      in_second;
    logic      drop_q;
    logic      first_beat;

    skip_decode #(.W(OP_W)) u_dec (
        .opcode    (op_code),
        .kind      (kind),
        .flag_load (flag_load)
    );

    // Separate the first words from the operand words.
    always_comb first_beat = op_valid && !in_second;

    skip_history u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .first_beat (first_beat),
        .beat       (op_valid),
        .kind       (kind),
        .repeat_hit (repeat_hit)
    );

    skip_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat      (op_valid),
        .two_word  (op_two_word),
        .flag_load (flag_load),
        .cond      (sf_cond),
        .kill      (kill),
        .sf_q      (sf_q),
        .in_second (in_second),
        .drop_q    (drop_q)
    );

    // A second word follows its first word. A first word yields to the flag or to the run rule.
    always_comb begin
        if (!op_valid)      kill = 1'b0;
        else if (in_second) kill = drop_q;
        else                kill = sf_q || repeat_hit;
    end

    AST_RUN_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (first_beat && repeat_hit) |-> kill); // R6
    AST_FLAG_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (first_beat && sf_q) |-> kill); // R2
endmodule

// File: tb/skip_ctrl_bench.sv
module skip_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] op_code = 8'h00;
    logic       op_two_word = 1'b0;
    logic       sf_cond = 1'b0;
    logic       kill;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state.
    bit       m_sf, m_in2, m_drop, m_pend;
    int       m_hist;

    always #2.5 clk = ~clk;

    skip_ctrl u_skip_ctrl (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_two_word(op_two_word), .sf_cond(sf_cond), .kill(kill)
    );

    function automatic int f_kind(input logic [7:0] op);
        if (op[7:4] == 4'h7) return 1;
        if (op[7:4] == 4'h4) return 2;
        if (op == 8'h24 || op == 8'h25) return 3;
        return 0;
    endfunction

    function automatic bit f_loads(input logic [7:0] op);
        return op[7:4] == 4'h6 || op[7:2] == 6'b000001 || op == 8'h22 ||
               op == 8'h1C || op == 8'h0F || op == 8'h0E || op == 8'h28 || op == 8'h20;
    endfunction

    function automatic bit f_two(input logic [7:0] op);
        return op[7:3] == 5'b01010 || op == 8'h0E;
    endfunction

    function automatic bit f_expect(input logic [7:0] op);
        if (m_in2) return m_drop;
        return m_sf || (f_kind(op) != 0 && f_kind(op) == m_hist);
    endfunction

    task automatic check(input bit act, input bit exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: kill=%0b expected %0b", req, act, exp);
        end
    endtask

    // Present one word, compare kill against the model, then step the model.
    task automatic beat(input logic [7:0] op, input bit cond, input string req);
        bit two, k;
        @(negedge clk);
        two = m_in2 ? 1'b0 : f_two(op);
        op_valid = 1'b1; op_code = op; op_two_word = two; sf_cond = cond;
        #1;
        k = f_expect(op);
        check(kill, k, req);
        if (m_in2) begin
            m_sf = !m_drop && m_pend && cond;
            m_in2 = 0; m_drop = 0; m_pend = 0;
        end else begin
            m_hist = f_kind(op);
            if (two) begin
                m_in2 = 1; m_drop = k; m_pend = !k && f_loads(op); m_sf = 0;
            end else begin
                m_sf = !k && f_loads(op) && cond;
            end
        end
    endtask

    task automatic idle(input int n, input logic [7:0] junk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 1'b0; op_code = junk; sf_cond = 1'b1; op_two_word = 1'b0;
            #1;
            check(kill, 1'b0, "R11");
        end
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] pool [16];
        int unused;
        unused = $urandom(32'h5EED_0042);
        m_sf = 0; m_in2 = 0; m_drop = 0; m_pend = 0; m_hist = 0;
        repeat (3) @(posedge clk);
        #1;
        check(kill, 1'b0, "R1");
        @(negedge clk); rst_n = 1'b1;
        beat(8'h73, 0, "R1");                  // first word after reset runs
        beat(8'h75, 1, "R6");                  // repeat load killed
        beat(8'h7F, 0, "R9");                  // whole run killed
        beat(8'h00, 0, "R9");                  // break
        beat(8'h71, 0, "R9");                  // new run starts
        beat(8'h42, 0, "R9");                  // different kind not chained
        beat(8'h48, 0, "R7");
        beat(8'h4F, 0, "R7");
        beat(8'h25, 0, "R9");
        beat(8'h24, 0, "R8");
        beat(8'h25, 0, "R8");
        beat(8'h68, 1, "R2");                  // add with carry sets the flag
        beat(8'h17, 0, "R2");                  // killed by the flag
        beat(8'h17, 0, "R4");                  // flag consumed
        beat(8'h1C, 0, "R3");
        beat(8'h17, 0, "R3");
        beat(8'h15, 1, "R5");                  // not a flag loader
        beat(8'h17, 0, "R5");
        beat(8'h0F, 1, "R2");
        beat(8'h64, 1, "R12");                 // killed add must not set flag
        beat(8'h17, 0, "R12");
        beat(8'h70, 0, "R10");
        beat(8'h0E, 0, "R10");                 // two-word compare, first word
        beat(8'h72, 1, "R10");                 // operand: condition applied, history untouched
        beat(8'h17, 0, "R10");                 // killed by flag
        beat(8'h22, 1, "R10");
        beat(8'h54, 0, "R10");                 // two-word jump killed by flag
        beat(8'h9A, 0, "R10");                 // its operand killed too
        beat(8'h17, 0, "R10");
        beat(8'h74, 0, "R11");
        idle(3, 8'h28);
        beat(8'h76, 0, "R11");                 // run survives idle cycles
        beat(8'h28, 1, "R2");
        idle(2, 8'h00);
        beat(8'h17, 0, "R11");                 // flag survives idle cycles

        pool = '{8'h70, 8'h7A, 8'h40, 8'h4C, 8'h24, 8'h25, 8'h68, 8'h22,
                 8'h0E, 8'h0F, 8'h1C, 8'h05, 8'h52, 8'h57, 8'h17, 8'h28};
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] op;
            if (m_in2) op = 8'($urandom);
            else if ($urandom_range(3) == 0) op = 8'($urandom);
            else op = pool[$urandom_range(15)];
            beat(op, 1'($urandom), "R9");
            if ($urandom_range(7) == 0) idle(1, 8'($urandom));
        end
        @(negedge clk); op_valid = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule